// File: doc/BRIEF.md
# Fixed-Priority Edge-Triggered Interrupt Requester

This block collects the interrupt request lines that an ISA-style expansion bus exposes to plug-in cards and turns them into one request at a time for the processor. Each line is asynchronous and active high. A request is latched when its line goes from low to high. It stays pending only while the line remains high. A line that falls before the processor acknowledges it loses its request.

Among pending requests the block presents the winner of a fixed, cascaded ranking. The upper bank, levels 9 to 15, ranks ahead of the lower bank, levels 3 to 7. Within each bank the lower number wins, so level 9 is the highest of all and level 7 the lowest. Levels 0, 1, 2 and 8 belong to the processor side and are never taken from the bus. Once a level is presented, the presented value is held until the processor acknowledges it. The acknowledge clears that one request, and the next winner appears in the following cycle.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Only bit positions 3–7 and 9–15 of `irq_lines` (bit index equals level number) can ever be presented; activity on bits 0, 1, 2 and 8 never raises `vec_valid`.
- R2: A low-to-high transition of an external line makes the request pending. When no other request is presented, `vec_valid` rises with `vec_level` equal to that line's number on the third rising clock edge after the input change, and not earlier.
- R3: After acknowledge, a line that simply stays high does not request again; the line must fall and rise again to make a new request.
- R4: If a pending line falls before it is acknowledged, its request is discarded, whether it was presented or still waiting.
- R5: Among pending requests the winner follows the rank order 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7 (first is highest).
- R6: While `vec_valid` is high, its line stays high and `ack` is low, `vec_level` and `vec_valid` do not change, even if a higher-ranked request arrives.
- R7: `ack` sampled high while `vec_valid` is high clears only the presented level. The next highest pending level, or `vec_valid` low if none remains, appears on the outputs after that same clock edge.
- R8: `ack` sampled while `vec_valid` is low has no effect on the outputs.
- R9: While reset is asserted, and until the first request, `vec_valid` is 0 and `vec_level` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines | input | 16 | Asynchronous request lines, bit n is level n (only 3–7, 9–15 used) |
| ack | input | 1 | Processor acknowledge of the presented level |
| vec_valid | output | 1 | A request is being presented |
| vec_level | output | 4 | Number of the presented level (0 when none) |

## Verification
A stale or wrong pending bit shows at the ports within one acknowledge. After the acknowledge, a request that should have been discarded reappears as the next level, or a real one goes missing from the acknowledge sequence. A mistake in the ranking shows on the first cycle the outputs reload with two or more requests pending. A counting error in the synchroniser or edge detector shifts the first appearance of `vec_valid` away from the third edge. Dropping the hold condition shows as `vec_level` changing the cycle after a higher line arrives.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_LVL = 16;
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int NUM_EXT = 12;

  // level numbers wired to the bus
  function automatic logic is_ext(input int lvl);
    return (lvl >= 3) && (lvl < NUM_LVL) && (lvl != 8);
  endfunction

  // rank 0 is the highest: upper bank 9..15, then lower bank 3..7
  function automatic int rank_level(input int rank);
    return (rank < 7) ? (9 + rank) : (rank - 4);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/irq_pend.sv
module irq_pend
  import irq_prio_pkg::*;
#(
  parameter int WIDTH = NUM_LVL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] line_s,
  input  logic [WIDTH-1:0] ack_clr,
  output logic [WIDTH-1:0] pend_q,
  output logic [WIDTH-1:0] pend_nxt
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] ext_mask;
  logic [WIDTH-1:0] rise;
  logic [WIDTH-1:0] keep;

  genvar l;
  generate
    for (l = 0; l < WIDTH; l++) begin : g_mask
      assign ext_mask[l] = is_ext(l);
    end
  endgenerate

  always_comb begin
    rise     = line_s & ~prev_q;
    keep     = pend_q & line_s & ~ack_clr;
    pend_nxt = (keep | rise) & ext_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= line_s;
      pend_q <= pend_nxt;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_prio_pkg::*;
#(
  parameter int WIDTH = NUM_LVL,
  parameter int LW    = LVL_W
) (
  input  logic [WIDTH-1:0] pend,
  output logic             any,
  output logic [LW-1:0]    level
);
  logic [NUM_EXT-1:0] ranked;

  genvar r;
  generate
    for (r = 0; r < NUM_EXT; r++) begin : g_rank
      assign ranked[r] = pend[rank_level(r)];
    end
  endgenerate

  always_comb begin
    any   = |ranked;
    level = '0;
    for (int i = NUM_EXT - 1; i >= 0; i--) begin
      if (ranked[i]) level = LW'(rank_level(i));
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] irq_lines,
  input  logic               ack,
  output logic               vec_valid,
  output logic [LVL_W-1:0]   vec_level
);
  logic [1:0]         rst_pipe_q;
  logic               rst_int_n;
  logic [NUM_LVL-1:0] sync_q;
  logic [NUM_LVL-1:0] ack_clr;
  logic [NUM_LVL-1:0] pend_q;
  logic [NUM_LVL-1:0] pend_nxt;
  logic               pick_any;
  logic [LVL_W-1:0]   pick_lvl;
  logic               out_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  irq_sync #(.WIDTH(NUM_LVL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_async(irq_lines), .d_sync(sync_q)
  );

  always_comb begin
    ack_clr = '0;
    if (vec_valid && ack) ack_clr[vec_level] = 1'b1;
  end

  irq_pend #(.WIDTH(NUM_LVL)) u_pend (
    .clk(clk), .rst_n(rst_int_n), .line_s(sync_q), .ack_clr(ack_clr),
    .pend_q(pend_q), .pend_nxt(pend_nxt)
  );

  irq_pick #(.WIDTH(NUM_LVL), .LW(LVL_W)) u_pick (
    .pend(pend_nxt), .any(pick_any), .level(pick_lvl)
  );

  // reload unless the presented request survives this cycle
  assign out_en = !(vec_valid && pend_nxt[vec_level]);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vec_valid <= 1'b0;
      vec_level <= '0;
    end else if (out_en) begin
      vec_valid <= pick_any;
      vec_level <= pick_lvl;
    end
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               ack,
  input logic               vec_valid,
  input logic [LVL_W-1:0]   vec_level,
  input logic [NUM_LVL-1:0] pend_q,
  input logic [NUM_LVL-1:0] sync_q
);
  AST_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> is_ext(int'(vec_level))); // R1

  AST_VALID_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> pend_q[vec_level]); // R2

  AST_DROP_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(sync_q)) == '0)); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !ack && sync_q[vec_level]) |=> (vec_valid && $stable(vec_level))); // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && ack) |=> !pend_q[$past(vec_level)]); // R7
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .vec_valid(vec_valid),
  .vec_level(vec_level), .pend_q(pend_q), .sync_q(sync_q)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic        clk;
  logic        rst_n;
  logic [15:0] irq_lines;
  logic        ack;
  logic        vec_valid;
  logic [3:0]  vec_level;
  int checks;
  int errors;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .ack(ack),
    .vec_valid(vec_valid), .vec_level(vec_level)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input bit v, input int lvl);
    check(vec_valid == v, {req, " valid"}, vec_valid, v);
    if (v) check(vec_level == lvl, {req, " level"}, vec_level, lvl);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_line(input int l, input bit v);
    irq_lines[l] = v;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic clear_all();
    irq_lines = '0;
    tick(5);
    if (vec_valid) pulse_ack();
    tick(2);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // R9 reset state
  task automatic t_reset();
    rst_n = 1'b0; ack = 1'b0; irq_lines = '0;
    tick(4);
    check(vec_valid == 1'b0, "R9 valid in reset", vec_valid, 0);
    check(vec_level == 4'd0, "R9 level in reset", vec_level, 0);
    rst_n = 1'b1;
    tick(4);
    check(vec_valid == 1'b0 && vec_level == 4'd0, "R9 after release", vec_valid, 0);
  endtask

  // R2 latency per level, R7 clear, R3 no re-request while held
  task automatic t_each_level();
    foreach (irq_lines[l]) begin
      if (l >= 3 && l != 8) begin
        set_line(l, 1'b1);
        tick(2);
        check(vec_valid == 1'b0, "R2 not before third edge", vec_valid, 0);
        tick(1);
        expect_out("R2 third edge", 1'b1, l);
        pulse_ack();
        expect_out("R7 cleared by ack", 1'b0, 0);
        tick(4);
        expect_out("R3 held line no repeat", 1'b0, 0);
        set_line(l, 1'b0);
        tick(4);
      end
    end
  endtask

  // R1 internal levels ignored
  task automatic t_internal();
    set_line(0, 1'b1); set_line(1, 1'b1); set_line(2, 1'b1); set_line(8, 1'b1);
    tick(6);
    expect_out("R1 internal bits ignored", 1'b0, 0);
    clear_all();
  endtask

  task automatic t_pair(input int a, input int b, input int win, input int lose);
    set_line(a, 1'b1); set_line(b, 1'b1);
    tick(4);
    expect_out("R5 pair winner", 1'b1, win);
    pulse_ack();
    expect_out("R7 pair runner-up", 1'b1, lose);
    pulse_ack();
    expect_out("R7 pair empty", 1'b0, 0);
    clear_all();
  endtask

  // R5 full ranking
  task automatic t_priority();
    int order [12] = '{9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7};
    t_pair(5, 12, 12, 5);
    t_pair(15, 3, 15, 3);
    t_pair(14, 13, 13, 14);
    t_pair(7, 6, 6, 7);
    foreach (order[i]) set_line(order[i], 1'b1);
    tick(4);
    foreach (order[i]) begin
      expect_out("R5 full order", 1'b1, order[i]);
      pulse_ack();
    end
    expect_out("R7 all served", 1'b0, 0);
    clear_all();
  endtask

  // R6 no preemption
  task automatic t_hold();
    set_line(6, 1'b1);
    tick(4);
    expect_out("R6 low level presented", 1'b1, 6);
    set_line(9, 1'b1);
    tick(5);
    expect_out("R6 held against higher", 1'b1, 6);
    pulse_ack();
    expect_out("R7 higher next", 1'b1, 9);
    pulse_ack();
    clear_all();
  endtask

  // R4 discard on drop
  task automatic t_drop();
    set_line(4, 1'b1);
    tick(4);
    expect_out("R4 presented before drop", 1'b1, 4);
    set_line(4, 1'b0);
    tick(4);
    expect_out("R4 presented dropped", 1'b0, 0);
    set_line(11, 1'b1); set_line(3, 1'b1);
    tick(4);
    expect_out("R4 setup", 1'b1, 11);
    set_line(3, 1'b0);
    tick(4);
    pulse_ack();
    expect_out("R4 waiting dropped", 1'b0, 0);
    clear_all();
  endtask

  // R3 new edge re-requests
  task automatic t_rerise();
    set_line(5, 1'b1);
    tick(4);
    pulse_ack();
    set_line(5, 1'b0);
    tick(4);
    set_line(5, 1'b1);
    tick(4);
    expect_out("R3 new edge requests", 1'b1, 5);
    pulse_ack();
    clear_all();
  endtask

  // R8 idle ack
  task automatic t_ack_idle();
    pulse_ack();
    pulse_ack();
    expect_out("R8 idle ack", 1'b0, 0);
    check(vec_level == 4'd0, "R8 level unchanged", vec_level, 0);
    set_line(10, 1'b1);
    tick(4);
    expect_out("R8 later request intact", 1'b1, 10);
    pulse_ack();
    clear_all();
  endtask

  initial begin
    checks = 0; errors = 0;
    t_reset();
    t_each_level();
    t_internal();
    t_priority();
    t_hold();
    t_drop();
    t_rerise();
    t_ack_idle();
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end
endmodule